// File: doc/BRIEF.md
# Configurable Multi-Term Multiply-Accumulate

This block is a purely combinational adder tree that forms one wrapped sum from a list of terms plus a set of single-bit increments. Each term is either a single operand or the product of two operands. Each term can be signed or unsigned, and each is either added or subtracted. Every operand arrives in one wide packed input `A`. Each bit of a second input `B` adds one to the sum when it is set.

The shape of the sum is fixed at elaboration by a packed configuration parameter. That parameter describes itself: a short header gives the width of the size fields, and a descriptor follows for each term. The design decodes this parameter into per-term control and slices `A` to match. A configuration whose operand widths do not add up to the width of `A` stops elaboration.

It suits a synthesis flow or a generator that needs a single accumulate cell for an arbitrary list of products and plain values. The cell has no clock, so the caller places registers around it as needed.

Top module: `cfg_macc`

## Requirements
- R1: Configuration bits 3..0 hold the size-field width NB, with bit 0 as the least significant bit.
- R2: Each term descriptor takes 2+2·NB configuration bits, starting at bit 4 and following one another in order. Its first bit is the signed flag and its second is the subtract flag. Next come the NB-bit width of operand a, then the NB-bit width of operand b, each least significant bit first.
- R3: Operands sit back to back in `A` from bit 0 in descriptor order: operand a of a term, then its operand b, with no gaps.
- R4: A term whose operand-b width is zero contributes operand a alone. Any other term contributes operand a times operand b.
- R5: When the signed flag is set, both operands of the term are sign-extended. When it is clear, both are zero-extended.
- R6: When the subtract flag is set, the term's value is subtracted from the sum. When it is clear, the value is added.
- R7: Each set bit of `B` adds one to `Y`, and `B` has no other effect.
- R8: `Y` equals the exact total modulo 2^Y_WIDTH, so a negative total wraps to the top of the range.
- R9: A descriptor whose two widths are both zero consumes no bits of `A` and adds nothing. The terms after it still take their operands from the next unused bits.
- R10: `Y` depends only on the present values of `A` and `B`. It settles in the same time step as an input change, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| A | input | A_WIDTH | All term operands, packed in descriptor order |
| B | input | B_WIDTH | Single-bit increments, each worth one |
| Y | output | Y_WIDTH | Wrapped sum of all terms and increments |

## Verification
All results are due zero cycles after a stimulus, because no register lies between `A`/`B` and `Y`. The bench changes the inputs just after a rising clock edge and reads `Y` one time unit later, before the next edge, so each comparison sees only the settled combinational value. One directed case changes the inputs in the middle of a cycle and reads `Y` within that same cycle, which checks that no clock is involved. The table vectors and the random vectors are compared against a reference that walks the configuration bit by bit.

// File: rtl/macc_pkg.sv
package macc_pkg;

  // Largest configuration vector the decode helpers accept.
  localparam int CFG_MAX = 1024;
  typedef logic [CFG_MAX-1:0] cfgVec_t;

  // Per-term strobes handed from the decoder to the datapath.
  typedef struct packed {
    logic isSigned;
    logic doSub;
    logic hasB;
  } termCtrl_t;

  function automatic int fieldVal(cfgVec_t c, int pos, int n);
    int v = 0;
    for (int i = 0; i < n; i++) v = v | (int'(c[pos+i]) << i);
    return v;
  endfunction

  function automatic int sizeBits(cfgVec_t c);
    return fieldVal(c, 0, 4);
  endfunction

  function automatic int descWidth(cfgVec_t c);
    return 2 + 2 * sizeBits(c);
  endfunction

  function automatic int descBase(cfgVec_t c, int t);
    return 4 + t * descWidth(c);
  endfunction

  function automatic int termCount(cfgVec_t c, int cfgWidth);
    return (cfgWidth - 4) / descWidth(c);
  endfunction

  function automatic int sizeA(cfgVec_t c, int t);
    return fieldVal(c, descBase(c, t) + 2, sizeBits(c));
  endfunction

  function automatic int sizeB(cfgVec_t c, int t);
    return fieldVal(c, descBase(c, t) + 2 + sizeBits(c), sizeBits(c));
  endfunction

  // Bit position in A where term t's first operand starts.
  function automatic int opOffset(cfgVec_t c, int t);
    int off = 0;
    for (int k = 0; k < t; k++) off = off + sizeA(c, k) + sizeB(c, k);
    return off;
  endfunction

endpackage

// File: rtl/macc_ctrl.sv
module macc_ctrl
  import macc_pkg::*;
#(
  parameter int A_WIDTH = 19,
  parameter int CONFIG_WIDTH = 44,
  parameter logic [CONFIG_WIDTH-1:0] CONFIG = '0,
  parameter int NUM_TERMS = 1
) (
  output termCtrl_t [NUM_TERMS-1:0] termCtrl
);

  localparam cfgVec_t CFG = cfgVec_t'(CONFIG);
  localparam int USED_A = opOffset(CFG, NUM_TERMS);
  localparam int USED_CFG = descBase(CFG, NUM_TERMS);

  // Elaboration-time consistency of the configuration.
  if (USED_A != A_WIDTH) begin : g_badAWidth
    $error("cfg_macc: descriptors consume %0d operand bits, A_WIDTH is %0d", USED_A, A_WIDTH);
  end
  if (USED_CFG != CONFIG_WIDTH) begin : g_badCfgWidth
    $error("cfg_macc: descriptors occupy %0d config bits, CONFIG_WIDTH is %0d", USED_CFG, CONFIG_WIDTH);
  end

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    localparam int BASE = descBase(CFG, t);
    localparam int SB = sizeB(CFG, t);
    assign termCtrl[t].isSigned = CONFIG[BASE];
    assign termCtrl[t].doSub = CONFIG[BASE+1];
    assign termCtrl[t].hasB = (SB != 0);
  end

endmodule

// File: rtl/macc_dp.sv
module macc_dp
  import macc_pkg::*;
#(
  parameter int A_WIDTH = 19,
  parameter int B_WIDTH = 3,
  parameter int Y_WIDTH = 10,
  parameter int CONFIG_WIDTH = 44,
  parameter logic [CONFIG_WIDTH-1:0] CONFIG = '0,
  parameter int NUM_TERMS = 1
) (
  input  logic [A_WIDTH-1:0] A,
  input  logic [B_WIDTH-1:0] B,
  input  termCtrl_t [NUM_TERMS-1:0] termCtrl,
  output logic [Y_WIDTH-1:0] Y
);

  localparam cfgVec_t CFG = cfgVec_t'(CONFIG);

  logic [Y_WIDTH-1:0] partialSum [NUM_TERMS+1];
  logic [Y_WIDTH-1:0] bitSum;

  assign partialSum[0] = '0;

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    localparam int SA = sizeA(CFG, t);
    localparam int SB = sizeB(CFG, t);
    localparam int OFF_A = opOffset(CFG, t);
    localparam int OFF_B = OFF_A + SA;

    logic [Y_WIDTH-1:0] extA;
    logic [Y_WIDTH-1:0] extB;
    logic [Y_WIDTH-1:0] termVal;
    logic [Y_WIDTH-1:0] contrib;

    for (genvar i = 0; i < Y_WIDTH; i++) begin : g_extA
      if (i < SA) begin : g_in
        assign extA[i] = A[OFF_A+i];
      end else if (SA > 0) begin : g_sx
        assign extA[i] = termCtrl[t].isSigned & A[OFF_A+SA-1];
      end else begin : g_zero
        assign extA[i] = 1'b0;
      end
    end

    for (genvar i = 0; i < Y_WIDTH; i++) begin : g_extB
      if (i < SB) begin : g_in
        assign extB[i] = A[OFF_B+i];
      end else if (SB > 0) begin : g_sx
        assign extB[i] = termCtrl[t].isSigned & A[OFF_B+SB-1];
      end else begin : g_zero
        assign extB[i] = 1'b0;
      end
    end

    assign termVal = termCtrl[t].hasB ? (extA * extB) : extA;
    assign contrib = termCtrl[t].doSub ? ({Y_WIDTH{1'b0}} - termVal) : termVal;
    assign partialSum[t+1] = partialSum[t] + contrib;
  end

  always_comb begin
    bitSum = '0;
    for (int i = 0; i < B_WIDTH; i++) begin
      bitSum = bitSum + {{(Y_WIDTH-1){1'b0}}, B[i]};
    end
  end

  assign Y = partialSum[NUM_TERMS] + bitSum;

endmodule

// File: rtl/cfg_macc.sv
module cfg_macc
  import macc_pkg::*;
#(
  parameter int A_WIDTH = 19,
  parameter int B_WIDTH = 3,
  parameter int Y_WIDTH = 10,
  parameter int CONFIG_WIDTH = 44,
  // NB=3; terms: signed-sub 4x3, plain 5, 3x2, empty, signed plain 2
  parameter logic [CONFIG_WIDTH-1:0] CONFIG = 44'h09004C14733
) (
  input  logic [A_WIDTH-1:0] A,
  input  logic [B_WIDTH-1:0] B,
  output logic [Y_WIDTH-1:0] Y
);

  localparam int NUM_TERMS = termCount(cfgVec_t'(CONFIG), CONFIG_WIDTH);

  termCtrl_t [NUM_TERMS-1:0] termCtrl;

  macc_ctrl #(
    .A_WIDTH(A_WIDTH),
    .CONFIG_WIDTH(CONFIG_WIDTH),
    .CONFIG(CONFIG),
    .NUM_TERMS(NUM_TERMS)
  ) u_ctrl (
    .termCtrl(termCtrl)
  );

  macc_dp #(
    .A_WIDTH(A_WIDTH),
    .B_WIDTH(B_WIDTH),
    .Y_WIDTH(Y_WIDTH),
    .CONFIG_WIDTH(CONFIG_WIDTH),
    .CONFIG(CONFIG),
    .NUM_TERMS(NUM_TERMS)
  ) u_dp (
    .A(A),
    .B(B),
    .termCtrl(termCtrl),
    .Y(Y)
  );

endmodule

// File: rtl/macc_chk.sv
module macc_chk #(
  parameter int A_WIDTH = 19,
  parameter int B_WIDTH = 3,
  parameter int Y_WIDTH = 10,
  parameter int CONFIG_WIDTH = 44,
  parameter logic [CONFIG_WIDTH-1:0] CONFIG = '0
) (
  input logic [A_WIDTH-1:0] A,
  input logic [B_WIDTH-1:0] B,
  input logic [Y_WIDTH-1:0] Y
);

  // Serial walk over the configuration, independent of the decode helpers.
  function automatic logic [Y_WIDTH-1:0] termsOnly(logic [A_WIDTH-1:0] a);
    int nb = 0;
    int cur = 4;
    int pos = 0;
    longint acc = 0;
    for (int i = 0; i < 4; i++) if (CONFIG[i]) nb = nb + (1 << i);
    while (cur + 2 + 2 * nb <= CONFIG_WIDTH) begin
      logic sg;
      logic sub;
      int wa;
      int wb;
      longint va;
      longint vb;
      longint tv;
      sg = CONFIG[cur];
      sub = CONFIG[cur+1];
      cur = cur + 2;
      wa = 0;
      for (int i = 0; i < nb; i++) if (CONFIG[cur+i]) wa = wa + (1 << i);
      cur = cur + nb;
      wb = 0;
      for (int i = 0; i < nb; i++) if (CONFIG[cur+i]) wb = wb + (1 << i);
      cur = cur + nb;
      va = 0;
      for (int i = 0; i < wa; i++) if (a[pos+i]) va = va + (longint'(1) << i);
      if (sg && wa > 0 && a[pos+wa-1]) va = va - (longint'(1) << wa);
      pos = pos + wa;
      vb = 0;
      for (int i = 0; i < wb; i++) if (a[pos+i]) vb = vb + (longint'(1) << i);
      if (sg && wb > 0 && a[pos+wb-1]) vb = vb - (longint'(1) << wb);
      pos = pos + wb;
      tv = (wb > 0) ? va * vb : va;
      acc = sub ? acc - tv : acc + tv;
    end
    return acc[Y_WIDTH-1:0];
  endfunction

  logic [Y_WIDTH-1:0] modelTerms;
  logic [Y_WIDTH-1:0] bitCount;

  always_comb begin
    modelTerms = termsOnly(A);
    bitCount = Y_WIDTH'($countones(B));
    if (!$isunknown({A, B, Y})) begin
      p_match_model_r3: assert (Y == modelTerms + bitCount)
        else $error("Y %0d differs from serial model %0d", Y, modelTerms + bitCount);
      p_term_part_r6: assert (Y - bitCount == modelTerms)
        else $error("term part of Y %0d differs from %0d", Y - bitCount, modelTerms);
      if (A == '0) begin
        p_bits_only_r7: assert (Y == bitCount)
          else $error("with A zero, Y %0d is not the B count %0d", Y, bitCount);
      end
      if (A == '0 && B == '0) begin
        p_idle_zero_r9: assert (Y == '0)
          else $error("all-zero inputs give Y %0d", Y);
      end
    end
  end

endmodule

bind cfg_macc macc_chk #(
  .A_WIDTH(A_WIDTH),
  .B_WIDTH(B_WIDTH),
  .Y_WIDTH(Y_WIDTH),
  .CONFIG_WIDTH(CONFIG_WIDTH),
  .CONFIG(CONFIG)
) u_chk (
  .A(A),
  .B(B),
  .Y(Y)
);

// File: tb/sim_cfg_macc.sv
module sim_cfg_macc;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int BW = 3;
  localparam int YW = 10;
  localparam int CW = 44;
  localparam logic [CW-1:0] CFG = 44'h09004C14733;

  // Vector layout: {s4[1:0], b2[1:0], a2[2:0], u1[4:0], b0[2:0], a0[3:0], B[2:0], Y[9:0]}
  localparam int NVEC = 5;
  localparam logic [31:0] VEC [NVEC] = '{
    {2'b00, 2'd0, 3'd0, 5'd0,  3'b000, 4'h0, 3'b000, 10'd0},
    {2'b10, 2'd3, 3'd7, 5'd31, 3'b100, 4'h8, 3'b111, 10'd21},
    {2'b01, 2'd0, 3'd0, 5'd0,  3'd3,   4'h7, 3'b010, 10'd1005},
    {2'b11, 2'd2, 3'd2, 5'd5,  3'b111, 4'hF, 3'b000, 10'd7},
    {2'b01, 2'd3, 3'd7, 5'd31, 3'd3,   4'h8, 3'b111, 10'd80}
  };

  logic clk = 1'b0;
  logic [AW-1:0] A = '0;
  logic [BW-1:0] B = '0;
  logic [YW-1:0] Y;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_macc u0 (.A(A), .B(B), .Y(Y));

  function automatic logic [YW-1:0] refModel(logic [AW-1:0] a, logic [BW-1:0] b);
    int nb = 0;
    int cur = 4;
    int pos = 0;
    longint acc = 0;
    for (int i = 0; i < 4; i++) if (CFG[i]) nb = nb + (1 << i);
    while (cur + 2 + 2 * nb <= CW) begin
      logic sg;
      logic sub;
      int wa;
      int wb;
      longint va;
      longint vb;
      sg = CFG[cur];
      sub = CFG[cur+1];
      cur = cur + 2;
      wa = 0;
      for (int i = 0; i < nb; i++) if (CFG[cur+i]) wa = wa + (1 << i);
      cur = cur + nb;
      wb = 0;
      for (int i = 0; i < nb; i++) if (CFG[cur+i]) wb = wb + (1 << i);
      cur = cur + nb;
      va = 0;
      for (int i = 0; i < wa; i++) if (a[pos+i]) va = va + (longint'(1) << i);
      if (sg && wa > 0 && a[pos+wa-1]) va = va - (longint'(1) << wa);
      pos = pos + wa;
      vb = 0;
      for (int i = 0; i < wb; i++) if (a[pos+i]) vb = vb + (longint'(1) << i);
      if (sg && wb > 0 && a[pos+wb-1]) vb = vb - (longint'(1) << wb);
      pos = pos + wb;
      if (wb > 0) va = va * vb;
      acc = sub ? acc - va : acc + va;
    end
    for (int i = 0; i < BW; i++) acc = acc + longint'(b[i]);
    return acc[YW-1:0];
  endfunction

  task automatic check(input string req, input logic [YW-1:0] expVal);
    nChecks++;
    if (Y !== expVal) begin
      nFails++;
      $display("FAIL %s: Y=%0d expected %0d (A=%h B=%b)", req, Y, expVal, A, B);
    end
  endtask

  // Drive just after a rising edge, sample one unit later.
  task automatic apply(input logic [AW-1:0] a, input logic [BW-1:0] b);
    @(posedge clk);
    #1;
    A = a;
    B = b;
    #1;
  endtask

  initial begin
    // Quiescent state: all-zero inputs give zero (R9, R7)
    apply('0, '0);
    check("R9 zero inputs", 10'd0);

    // Vector table (R3 R4 R5 R6 R7 R8)
    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][31:13], VEC[v][12:10]);
      check($sformatf("R3 table vector %0d", v), VEC[v][9:0]);
    end

    // R4: plain term passes through unchanged
    apply({2'b00, 2'd0, 3'd0, 5'd19, 3'd0, 4'h0}, 3'b000);
    check("R4 plain term", 10'd19);
    // R4: product with a zero b operand yields nothing
    apply({2'b00, 2'd0, 3'd5, 5'd0, 3'd0, 4'h0}, 3'b000);
    check("R4 product with zero b", 10'd0);
    // R5: signed plain term of -2 wraps (R8)
    apply({2'b10, 2'd0, 3'd0, 5'd0, 3'd0, 4'h0}, 3'b000);
    check("R5 R8 signed plain -2", 10'd1022);
    // R5 R6: (-1)*(1) subtracted gives +1
    apply({2'b00, 2'd0, 3'd0, 5'd0, 3'b001, 4'hF}, 3'b000);
    check("R6 signed subtract", 10'd1);
    // R5: unsigned term zero-extends 7*2
    apply({2'b00, 2'd2, 3'd7, 5'd0, 3'd0, 4'h0}, 3'b000);
    check("R5 unsigned product", 10'd14);
    // R7: B contributes its count only
    apply('0, 3'b101);
    check("R7 B count", 10'd2);
    // R9 R1 R2: last term sits right after the empty descriptor
    apply({2'b01, 17'd0}, 3'b000);
    check("R1 R2 R9 term after empty descriptor", 10'd1);

    // R10: mid-cycle change settles with no clock edge
    @(negedge clk);
    A = {2'b00, 2'd0, 3'd0, 5'd9, 3'd0, 4'h0};
    B = 3'b011;
    #1;
    check("R10 no clock needed", 10'd11);

    // Random sweep against the reference model (R3 R8)
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] ra;
      logic [BW-1:0] rb;
      ra = AW'($urandom);
      rb = BW'($urandom);
      apply(ra, rb);
      check("R3 R8 random", refModel(ra, rb));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule